// File: doc/BRIEF.md
# Serial Receive Ready and Interrupt Logic

This block is the receive half of a buffered synchronous serial port. It samples an external bit clock, serial data and frame-sync line, assembles fixed-width elements MSB first, moves each finished element through a buffer register into a data register the CPU can read, and keeps a ready flag that says unread data is waiting.

A single interrupt line is driven from one of four sources picked by a 2-bit mode input: the ready flag itself, the end of a programmable subframe, every frame-sync pulse, or a frame-sync error. A one-cycle DMA strobe fires each time the data register is loaded, so software may poll the flag, let a DMA engine move data, or take interrupts. A sticky sync-error bit is visible whatever the mode.

The serial pins are brought into the system clock domain through a two-flop synchroniser, and the rising edge of the synchronised bit clock is used as a sampling tick, so all state lives in one clock domain.

Top module: `serial_rx_ready`

## Requirements
- R1: When a completed element is copied from the buffer register to the data register, `rdy` rises and `dma_evt` is high for exactly that one cycle; `rd_data` then holds the element.
- R2: A `rd_stb` pulse clears `rdy`, unless a new copy lands in the same cycle, in which case `rdy` stays high.
- R3: While `rx_run` is 0, or while `rst` is high, `rdy` and `sync_err` are 0, the bit and subframe state is cleared, and serial activity causes no copy, no DMA strobe and no interrupt.
- R4: With `irq_mode` = 2'b00, `irq` is a level equal to `rdy`.
- R5: With `irq_mode` = 2'b01, `irq` pulses once each time the number of elements completed since the last frame sync reaches `subf_len`+1 (1 to 16); the count then restarts, and every frame sync restarts it too.
- R6: With `irq_mode` = 2'b10, `irq` pulses once for every frame-sync pulse sampled while `rx_run` is 1.
- R7: A frame sync that arrives while an element is only partly shifted in is a sync error: the partial element is dropped, a new element starts, `sync_err` is set and stays set until `rx_run` goes low or `rst`; with `irq_mode` = 2'b11, `irq` pulses once per error. A frame sync exactly at an element boundary is not an error.
- R8: A bit is sampled on each rising edge of `ser_clk`; `ser_fs` high on that edge marks the first (most significant) bit of a new frame, and further elements of `ELEM_W` bits follow back to back until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_run | input | 1 | Receiver enable; 0 holds the receiver in reset |
| ser_clk | input | 1 | Serial bit clock, sampled |
| ser_dat | input | 1 | Serial data |
| ser_fs | input | 1 | Frame sync |
| irq_mode | input | 2 | Interrupt source: 00 ready, 01 subframe end, 10 frame sync, 11 sync error |
| subf_len | input | 4 | Elements per subframe minus one |
| rd_stb | input | 1 | One-cycle read of the data register |
| rd_data | output | ELEM_W | Data register |
| rdy | output | 1 | Receive-ready flag |
| irq | output | 1 | Interrupt |
| dma_evt | output | 1 | One-cycle DMA request per loaded element |
| sync_err | output | 1 | Sticky frame-sync error |

## Verification
The bench aims at subframe counting at both ends of its range (a length of one, which must interrupt on every element, and sixteen) and at a frame sync in mid-subframe, which a counter that ignored frame sync would turn into an early pulse. It injects a frame sync after a few bits of an element, where a design that failed to drop the partial element would present corrupt data or an extra DMA strobe, and a frame sync exactly on an element boundary, where an off-by-one bit counter would flag a false error. It also drives serial frames with the receiver disabled, which a design that did not gate its state would turn into ready flags or interrupts, and checks that the error bit survives good frames but not a receiver reset.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    IRQ_READY = 2'b00,
    IRQ_SUBF  = 2'b01,
    IRQ_FSYNC = 2'b10,
    IRQ_SERR  = 2'b11
  } irq_src_e;

endpackage

// File: rtl/serial_rx_sync.sv
// Brings the serial pins into the system clock domain and marks the
// rising edge of the bit clock with a one-cycle tick.
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_dat,
  input  logic ser_fs,
  output logic bit_tick,
  output logic dat_s,
  output logic fs_s
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] clk_sr;
  logic [STAGES-1:0] dat_sr;
  logic [STAGES-1:0] fs_sr;
  logic              clk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sr   <= '0;
      dat_sr   <= '0;
      fs_sr    <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sr   <= {clk_sr[STAGES-2:0], ser_clk};
      dat_sr   <= {dat_sr[STAGES-2:0], ser_dat};
      fs_sr    <= {fs_sr[STAGES-2:0], ser_fs};
      clk_prev <= clk_sr[LAST];
    end
  end

  assign bit_tick = clk_sr[LAST] & ~clk_prev;
  assign dat_s    = dat_sr[LAST];
  assign fs_s     = fs_sr[LAST];
endmodule

// File: rtl/serial_rx_shift.sv
// Element assembly, frame tracking, subframe counting and sync-error
// detection. All outputs are registered one-cycle pulses plus data.
module serial_rx_shift #(
  parameter int ELEM_W = 8,
  parameter int SUBF_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              bit_tick,
  input  logic              dat,
  input  logic              fs,
  input  logic [SUBF_W-1:0] subf_len,
  output logic              elem_done,
  output logic [ELEM_W-1:0] elem_data,
  output logic              fs_evt,
  output logic              err_evt,
  output logic              subf_end
);
  localparam int CNT_W = $clog2(ELEM_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ELEM_W - 1);

  logic [ELEM_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic [SUBF_W-1:0] sub_cnt;
  logic              in_frame;
  logic [ELEM_W-1:0] shreg_nx;

  assign shreg_nx = {shreg[ELEM_W-2:0], dat};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      sub_cnt   <= '0;
      in_frame  <= 1'b0;
      elem_done <= 1'b0;
      elem_data <= '0;
      fs_evt    <= 1'b0;
      err_evt   <= 1'b0;
      subf_end  <= 1'b0;
    end else begin
      elem_done <= 1'b0;
      fs_evt    <= 1'b0;
      err_evt   <= 1'b0;
      subf_end  <= 1'b0;
      if (bit_tick) begin
        if (fs) begin
          // new frame: first bit of a fresh element
          fs_evt   <= 1'b1;
          err_evt  <= (bit_cnt != '0);
          in_frame <= 1'b1;
          shreg    <= {{(ELEM_W-1){1'b0}}, dat};
          bit_cnt  <= CNT_W'(1);
          sub_cnt  <= '0;
        end else if (in_frame) begin
          shreg <= shreg_nx;
          if (bit_cnt == LAST_BIT) begin
            bit_cnt   <= '0;
            elem_done <= 1'b1;
            elem_data <= shreg_nx;
            if (sub_cnt == subf_len) begin
              subf_end <= 1'b1;
              sub_cnt  <= '0;
            end else begin
              sub_cnt <= sub_cnt + 1'b1;
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx_status.sv
// Buffer and data registers, ready flag, DMA strobe, sticky error and
// the interrupt source multiplexer.
module serial_rx_status
  import serial_rx_pkg::*;
#(
  parameter int ELEM_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              elem_done,
  input  logic [ELEM_W-1:0] elem_data,
  input  logic              fs_evt,
  input  logic              err_evt,
  input  logic              subf_end,
  input  logic              rd_stb,
  input  logic [1:0]        irq_mode,
  output logic [ELEM_W-1:0] rd_data,
  output logic              rdy,
  output logic              irq,
  output logic              dma_evt,
  output logic              sync_err
);
  logic [ELEM_W-1:0] buf_q;
  logic              copy_pend;
  logic              rdy_d;
  logic              irq_d;
  logic              err_d;

  always_comb begin
    rdy_d = rdy;
    if (rd_stb)    rdy_d = 1'b0;
    if (copy_pend) rdy_d = 1'b1;
    if (!run)      rdy_d = 1'b0;
  end

  assign err_d = run & (sync_err | err_evt);

  always_comb begin
    unique case (irq_src_e'(irq_mode))
      IRQ_READY: irq_d = rdy_d;
      IRQ_SUBF:  irq_d = subf_end & run;
      IRQ_FSYNC: irq_d = fs_evt & run;
      IRQ_SERR:  irq_d = err_evt & run;
      default:   irq_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q     <= '0;
      copy_pend <= 1'b0;
      rd_data   <= '0;
      rdy       <= 1'b0;
      irq       <= 1'b0;
      dma_evt   <= 1'b0;
      sync_err  <= 1'b0;
    end else begin
      if (elem_done) buf_q <= elem_data;
      copy_pend <= elem_done & run;
      if (copy_pend && run) rd_data <= buf_q;
      rdy      <= rdy_d;
      dma_evt  <= copy_pend & run;
      sync_err <= err_d;
      irq      <= irq_d;
    end
  end
endmodule

// File: rtl/serial_rx_ready.sv
module serial_rx_ready #(
  parameter int ELEM_W      = 8,
  parameter int SUBF_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_run,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_fs,
  input  logic [1:0]        irq_mode,
  input  logic [SUBF_W-1:0] subf_len,
  input  logic              rd_stb,
  output logic [ELEM_W-1:0] rd_data,
  output logic              rdy,
  output logic              irq,
  output logic              dma_evt,
  output logic              sync_err
);
  logic              bit_tick;
  logic              dat_s;
  logic              fs_s;
  logic              elem_done;
  logic [ELEM_W-1:0] elem_data;
  logic              fs_evt;
  logic              err_evt;
  logic              subf_end;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .ser_clk  (ser_clk),
    .ser_dat  (ser_dat),
    .ser_fs   (ser_fs),
    .bit_tick (bit_tick),
    .dat_s    (dat_s),
    .fs_s     (fs_s)
  );

  serial_rx_shift #(.ELEM_W(ELEM_W), .SUBF_W(SUBF_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .run       (rx_run),
    .bit_tick  (bit_tick),
    .dat       (dat_s),
    .fs        (fs_s),
    .subf_len  (subf_len),
    .elem_done (elem_done),
    .elem_data (elem_data),
    .fs_evt    (fs_evt),
    .err_evt   (err_evt),
    .subf_end  (subf_end)
  );

  serial_rx_status #(.ELEM_W(ELEM_W)) u_status (
    .clk       (clk),
    .rst       (rst),
    .run       (rx_run),
    .elem_done (elem_done),
    .elem_data (elem_data),
    .fs_evt    (fs_evt),
    .err_evt   (err_evt),
    .subf_end  (subf_end),
    .rd_stb    (rd_stb),
    .irq_mode  (irq_mode),
    .rd_data   (rd_data),
    .rdy       (rdy),
    .irq       (irq),
    .dma_evt   (dma_evt),
    .sync_err  (sync_err)
  );
endmodule

// File: rtl/serial_rx_ready_chk.sv
module serial_rx_ready_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_run,
  input logic [1:0] irq_mode,
  input logic       rd_stb,
  input logic       rdy,
  input logic       irq,
  input logic       dma_evt,
  input logic       sync_err
);
  a_r1_rise_with_dma: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy) |-> dma_evt);

  a_r2_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rdy && rd_stb) |=> (!rdy || dma_evt));

  a_r3_off_clears: assert property (@(posedge clk) disable iff (rst)
    !rx_run |=> (!rdy && !sync_err));

  a_r3_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rx_run) && !$past(rx_run, 2)) |-> (!irq && !dma_evt));

  a_r4_ready_level: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_mode) == 2'b00) |-> (irq == rdy));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (sync_err && rx_run) |=> sync_err);
endmodule

bind serial_rx_ready serial_rx_ready_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_run   (rx_run),
  .irq_mode (irq_mode),
  .rd_stb   (rd_stb),
  .rdy      (rdy),
  .irq      (irq),
  .dma_evt  (dma_evt),
  .sync_err (sync_err)
);

// File: tb/tb_serial_rx_ready.sv
`timescale 1ns/1ps
module tb_serial_rx_ready;
  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_run = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       ser_fs = 1'b0;
  logic [1:0] irq_mode = 2'b00;
  logic [3:0] subf_len = 4'd0;
  logic       rd_stb = 1'b0;
  logic [W-1:0] rd_data;
  logic       rdy, irq, dma_evt, sync_err;

  int total = 0;
  int bad = 0;
  int irq_pulses = 0;
  int dma_cnt = 0;
  logic irq_q = 1'b0;

  always #2.5 clk = ~clk;

  serial_rx_ready #(.ELEM_W(W)) dut (
    .clk(clk), .rst(rst), .rx_run(rx_run), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .ser_fs(ser_fs), .irq_mode(irq_mode),
    .subf_len(subf_len), .rd_stb(rd_stb), .rd_data(rd_data),
    .rdy(rdy), .irq(irq), .dma_evt(dma_evt), .sync_err(sync_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (irq && !irq_q) irq_pulses++;
      if (dma_evt) dma_cnt++;
    end
    irq_q = irq;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic f, input logic d);
    @(negedge clk);
    ser_fs = f; ser_dat = d;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send_elem(input logic first, input logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) send_bit(first && (i == W - 1), v[i]);
  endtask

  task automatic settle();
    ser_fs = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    @(negedge clk);
  endtask

  function automatic int pulses_expected(input int n, input int len);
    return n / (len + 1);
  endfunction

  initial begin : wdog
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [W-1:0] v;
    int p0, d0, n, len;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R3 reset rdy", rdy, 0);
    check("R3 reset irq", irq, 0);
    check("R3 reset sync_err", sync_err, 0);
    rx_run = 1'b1;
    @(negedge clk);

    // ready mode: single element frames
    irq_mode = 2'b00;
    for (int k = 0; k < 6; k++) begin
      v = (k == 0) ? 8'hA5 : W'($urandom);
      d0 = dma_cnt;
      send_elem(1'b1, v);
      settle();
      check("R8 data", rd_data, v);
      check("R1 rdy set", rdy, 1);
      check("R1 one dma strobe", dma_cnt - d0, 1);
      check("R4 irq follows rdy", irq, 1);
      do_read();
      check("R2 read clears rdy", rdy, 0);
      check("R4 irq follows rdy low", irq, 0);
    end

    // back-to-back elements in one frame, last one visible
    d0 = dma_cnt;
    send_elem(1'b1, 8'h3C);
    send_elem(1'b0, 8'hC3);
    send_elem(1'b0, 8'h81);
    settle();
    check("R8 back to back last data", rd_data, 8'h81);
    check("R1 dma per element", dma_cnt - d0, 3);
    do_read();

    // subframe mode with random lengths
    irq_mode = 2'b01;
    for (int k = 0; k < 4; k++) begin
      len = (k == 0) ? 0 : int'($urandom_range(1, 3));
      n = (len + 1) * int'($urandom_range(1, 3)) + int'($urandom_range(0, len));
      subf_len = 4'(len);
      p0 = irq_pulses;
      for (int e = 0; e < n; e++) begin
        v = W'($urandom);
        send_elem(e == 0, v);
      end
      settle();
      check("R5 subframe pulses", irq_pulses - p0, pulses_expected(n, len));
      check("R8 last data", rd_data, v);
      do_read();
    end
    // subframe of sixteen
    subf_len = 4'd15;
    p0 = irq_pulses;
    for (int e = 0; e < 16; e++) send_elem(e == 0, W'(e));
    settle();
    check("R5 sixteen element subframe", irq_pulses - p0, 1);
    // frame sync restarts the subframe count
    subf_len = 4'd2;
    p0 = irq_pulses;
    send_elem(1'b1, 8'h11);
    send_elem(1'b0, 8'h22);
    send_elem(1'b1, 8'h33);
    send_elem(1'b0, 8'h44);
    settle();
    check("R5 count restarts on frame sync", irq_pulses - p0, 0);
    send_elem(1'b0, 8'h55);
    settle();
    check("R5 pulse after restart", irq_pulses - p0, 1);
    do_read();

    // frame-sync mode
    irq_mode = 2'b10;
    p0 = irq_pulses;
    for (int k = 0; k < 3; k++) send_elem(1'b1, W'($urandom));
    settle();
    check("R6 pulse per frame sync", irq_pulses - p0, 3);
    do_read();

    // receiver held off: serial traffic ignored
    rx_run = 1'b0;
    p0 = irq_pulses; d0 = dma_cnt;
    send_elem(1'b1, 8'hEE);
    send_elem(1'b1, 8'h77);
    settle();
    check("R3 no irq while off", irq_pulses - p0, 0);
    check("R3 no dma while off", dma_cnt - d0, 0);
    check("R3 rdy low while off", rdy, 0);
    rx_run = 1'b1;
    @(negedge clk);

    // sync error mode
    irq_mode = 2'b11;
    p0 = irq_pulses; d0 = dma_cnt;
    send_elem(1'b1, 8'h10);
    send_elem(1'b1, 8'h20);       // frame sync on a boundary
    settle();
    check("R7 boundary sync no error", sync_err, 0);
    check("R7 boundary no irq", irq_pulses - p0, 0);
    do_read();
    d0 = dma_cnt;
    send_bit(1'b1, 1'b1);
    send_bit(1'b0, 1'b0);
    send_bit(1'b0, 1'b1);
    send_elem(1'b1, 8'h5A);       // early frame sync
    settle();
    check("R7 error set", sync_err, 1);
    check("R7 one error irq", irq_pulses - p0, 1);
    check("R7 partial element dropped", rd_data, 8'h5A);
    check("R7 single dma", dma_cnt - d0, 1);
    do_read();

    // error stays readable in ready mode and survives good frames
    irq_mode = 2'b00;
    send_elem(1'b1, 8'h66);
    settle();
    check("R7 error sticky", sync_err, 1);
    check("R4 irq with rdy", irq, 1);
    rx_run = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 off clears error", sync_err, 0);
    check("R3 off clears rdy", rdy, 0);
    check("R4 irq low when off", irq, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule